// File: doc/BRIEF.md
# Operation Phase Sequencer

This block orders the work of an arithmetic and memory unit through a fixed series of up to eight operation phases. Each phase has a fixed meaning: P0 shift or shift-and-round, P1 transfer, P2 print, P3 first-accumulator arithmetic, P4 second-accumulator arithmetic, P5 third-accumulator arithmetic, P6 clear, P7 multiply or divide. A start request latches a phase-enable mask that names the phases the current operation needs. The block then walks the phases in ascending order and passes over disabled phases. Inside each enabled phase it runs a step counter S0 to S(N-1) that the datapath advances.

The outputs are one-hot phase and step vectors for the datapath decoders, a pulse that marks the first cycle of each phase, a per-phase end pulse, and an operation-end pulse. A watchdog sets a sticky lockout flag when an operation overruns its cycle budget. That flag stops the sequencer and refuses new starts until reset.

Top module: `op_phase_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows all of `phase_o`, `step_o`, `init_o`, `phase_end_o`, `op_end_o`, `busy_o` and `lock_o` at zero.
- R2: `start_i`, sampled high while idle and not locked, latches `phase_en_i`. From the next cycle `busy_o` is high and the sequencer visits phase indices 0 up to NUM_PHASES-1 in ascending order. During an enabled phase k, `phase_o` has only bit k set.
- R3: A phase whose latched enable bit is 0 takes exactly one clock. In that clock `phase_o`, `step_o`, `init_o` and `phase_end_o` are all zero.
- R4: `init_o` is high only in the first cycle of each enabled phase, and the step is S0 (`step_o` bit 0) in that cycle.
- R5: In an enabled phase, `step_done_i` without `phase_done_i` advances the one-hot step by one position on the next cycle. The step stays at S(NUM_STEPS-1) once it is reached. With no phase active, `step_o` is zero and `step_done_i` has no effect.
- R6: `phase_end_o` is high in the same cycle that `phase_done_i` is high during an enabled phase. The next phase index follows on the next cycle, starting again at S0.
- R7: After the last phase index ends or is skipped, `op_end_o` is high for exactly one cycle, on the next cycle, and `busy_o` is low from that cycle on.
- R8: An operation that has not completed its last phase within TIMEOUT_CYCLES cycles after the start is sampled sets `lock_o`. The phase and step outputs then go to zero and `busy_o` goes low. `lock_o` stays high and `start_i` is ignored until reset.
- R9: `start_i` and changes on `phase_en_i` while `busy_o` is high have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| phase_en_i | input | NUM_PHASES | Phases needed by the operation, bit k = phase k |
| step_done_i | input | 1 | Datapath request to move to the next step |
| phase_done_i | input | 1 | Datapath request to end the current phase |
| phase_o | output | NUM_PHASES | One-hot active phase, zero when none |
| step_o | output | NUM_STEPS | One-hot active step, zero when no phase active |
| init_o | output | 1 | First cycle of an enabled phase |
| phase_end_o | output | 1 | End of the current phase |
| op_end_o | output | 1 | One-cycle end-of-operation pulse |
| busy_o | output | 1 | Operation in progress |
| lock_o | output | 1 | Sticky incomplete-operation lockout |

## Verification
The bench keeps the default eight phases and ten steps, so step saturation and the full phase order, including the last index, are exercised. It lowers TIMEOUT_CYCLES to 64. That value is long enough that normal operations with frequent phase ends finish, and short enough that withholding `phase_done_i` trips the lockout within a few dozen cycles. The lockout's persistence, start refusal and reset release can therefore all be covered in a short run.

// File: rtl/ops_seq_pkg.sv
`timescale 1ns/1ps
package ops_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Bits needed to index n items (at least 1).
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ops_phase_ctrl.sv
`timescale 1ns/1ps
module ops_phase_ctrl
    import ops_seq_pkg::*;
#(
    parameter int unsigned NPH = 8,
    localparam int unsigned PW = idx_width(NPH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [NPH-1:0] mask_i,
    input  logic           phase_done_i,
    input  logic           lock_i,
    input  logic           trip_i,
    output logic           run_o,
    output logic [PW-1:0]  ph_o,
    output logic           active_o,
    output logic           leave_o,
    output logic           finish_o,
    output logic           fresh_o,
    output logic           op_end_o
);

    seq_state_e     state_q;
    logic [PW-1:0]  ph_q;
    logic [NPH-1:0] mask_q;
    logic           fresh_q;
    logic           op_end_q;
    logic           running;
    logic           last_ph;

    assign running  = (state_q == SEQ_RUN);
    assign last_ph  = (ph_q == PW'(NPH - 1));
    assign active_o = running && mask_q[ph_q];
    // Disabled phase leaves at once; enabled phase leaves on request.
    assign leave_o  = running && (!mask_q[ph_q] || phase_done_i);
    assign finish_o = leave_o && last_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            ph_q     <= '0;
            mask_q   <= '0;
            fresh_q  <= 1'b0;
            op_end_q <= 1'b0;
        end else begin
            op_end_q <= 1'b0;
            if (!running) begin
                if (start_i && !lock_i) begin
                    state_q <= SEQ_RUN;
                    ph_q    <= '0;
                    mask_q  <= mask_i;
                    fresh_q <= 1'b1;
                end
            end else if (trip_i) begin
                state_q <= SEQ_IDLE;
                fresh_q <= 1'b0;
            end else if (leave_o) begin
                fresh_q <= 1'b1;
                if (last_ph) begin
                    state_q  <= SEQ_IDLE;
                    op_end_q <= 1'b1;
                end else begin
                    ph_q <= ph_q + PW'(1);
                end
            end else begin
                fresh_q <= 1'b0;
            end
        end
    end

    assign run_o    = running;
    assign ph_o     = ph_q;
    assign fresh_o  = fresh_q;
    assign op_end_o = op_end_q;

endmodule

// File: rtl/ops_step_counter.sv
`timescale 1ns/1ps
module ops_step_counter
    import ops_seq_pkg::*;
#(
    parameter int unsigned NST = 10,
    localparam int unsigned SW = idx_width(NST)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          adv_i,
    output logic [SW-1:0] st_o
);

    logic [SW-1:0] st_q;
    logic          at_top;

    assign at_top = (st_q == SW'(NST - 1));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            st_q <= '0;
        end else if (adv_i && !at_top) begin
            st_q <= st_q + SW'(1);
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/ops_watchdog.sv
`timescale 1ns/1ps
module ops_watchdog
    import ops_seq_pkg::*;
#(
    parameter int unsigned LIMIT = 4096,
    localparam int unsigned CW = idx_width(LIMIT)
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic finish_i,
    output logic trip_o,
    output logic lock_o
);

    logic [CW-1:0] cnt_q;
    logic          lock_q;

    // Final budgeted cycle reached without completing the operation.
    assign trip_o = run_i && (cnt_q == CW'(LIMIT - 1)) && !finish_i;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (trip_o) begin
            lock_q <= 1'b1;
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/op_phase_sequencer.sv
`timescale 1ns/1ps
module op_phase_sequencer
    import ops_seq_pkg::*;
#(
    parameter int unsigned NUM_PHASES     = 8,
    parameter int unsigned NUM_STEPS      = 10,
    parameter int unsigned TIMEOUT_CYCLES = 4096
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [NUM_PHASES-1:0] phase_en_i,
    input  logic                  step_done_i,
    input  logic                  phase_done_i,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic [NUM_STEPS-1:0]  step_o,
    output logic                  init_o,
    output logic                  phase_end_o,
    output logic                  op_end_o,
    output logic                  busy_o,
    output logic                  lock_o
);

    localparam int unsigned PW = idx_width(NUM_PHASES);
    localparam int unsigned SW = idx_width(NUM_STEPS);

    logic          run;
    logic [PW-1:0] ph;
    logic          active;
    logic          leave;
    logic          finish;
    logic          fresh;
    logic          trip;
    logic          locked;
    logic [SW-1:0] st;

    ops_phase_ctrl #(.NPH(NUM_PHASES)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .mask_i       (phase_en_i),
        .phase_done_i (phase_done_i),
        .lock_i       (locked),
        .trip_i       (trip),
        .run_o        (run),
        .ph_o         (ph),
        .active_o     (active),
        .leave_o      (leave),
        .finish_o     (finish),
        .fresh_o      (fresh),
        .op_end_o     (op_end_o)
    );

    ops_step_counter #(.NST(NUM_STEPS)) u_step (
        .clk     (clk),
        .rst     (rst),
        .clear_i (leave || !run),
        .adv_i   (active && step_done_i && !phase_done_i),
        .st_o    (st)
    );

    ops_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .finish_i (finish),
        .trip_o   (trip),
        .lock_o   (locked)
    );

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase_dec
        assign phase_o[g] = active && (ph == PW'(g));
    end

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step_dec
        assign step_o[g] = active && (st == SW'(g));
    end

    assign init_o      = active && fresh;
    assign phase_end_o = active && phase_done_i;
    assign busy_o      = run;
    assign lock_o      = locked;

endmodule

// File: rtl/ops_seq_checker.sv
`timescale 1ns/1ps
module ops_seq_checker #(
    parameter int unsigned NPH = 8,
    parameter int unsigned NST = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           step_done_i,
    input logic           phase_done_i,
    input logic [NPH-1:0] phase_o,
    input logic [NST-1:0] step_o,
    input logic           init_o,
    input logic           phase_end_o,
    input logic           op_end_o,
    input logic           busy_o,
    input logic           lock_o
);

    a_r2_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_o));

    a_r5_step_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_o));

    a_r5_step_with_phase: assert property (@(posedge clk) disable iff (rst)
        ((phase_o != '0) == (step_o != '0)));

    a_r4_init_at_s0: assert property (@(posedge clk) disable iff (rst)
        init_o |-> step_o[0]);

    a_r6_end_in_phase: assert property (@(posedge clk) disable iff (rst)
        phase_end_o |-> (phase_o != '0));

    a_r5_step_advance: assert property (@(posedge clk) disable iff (rst)
        ((step_o != '0) && step_done_i && !phase_done_i && !step_o[NST-1])
        |=> (lock_o || step_o == ($past(step_o) << 1)));

    a_r7_op_end_single: assert property (@(posedge clk) disable iff (rst)
        op_end_o |=> !op_end_o);

    a_r7_op_end_idle: assert property (@(posedge clk) disable iff (rst)
        op_end_o |-> !busy_o);

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> lock_o);

    a_r8_lock_idle: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> (!busy_o && phase_o == '0));

endmodule

bind op_phase_sequencer ops_seq_checker #(
    .NPH(NUM_PHASES),
    .NST(NUM_STEPS)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .step_done_i  (step_done_i),
    .phase_done_i (phase_done_i),
    .phase_o      (phase_o),
    .step_o       (step_o),
    .init_o       (init_o),
    .phase_end_o  (phase_end_o),
    .op_end_o     (op_end_o),
    .busy_o       (busy_o),
    .lock_o       (lock_o)
);

// File: tb/op_phase_sequencer_test.sv
`timescale 1ns/1ps
module op_phase_sequencer_test;

    localparam int NPH = 8;
    localparam int NST = 10;
    localparam int TO  = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [NPH-1:0] phase_en_i = '0;
    logic           step_done_i = 1'b0;
    logic           phase_done_i = 1'b0;
    logic [NPH-1:0] phase_o;
    logic [NST-1:0] step_o;
    logic           init_o, phase_end_o, op_end_o, busy_o, lock_o;

    op_phase_sequencer #(
        .NUM_PHASES(NPH), .NUM_STEPS(NST), .TIMEOUT_CYCLES(TO)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .phase_en_i(phase_en_i),
        .step_done_i(step_done_i), .phase_done_i(phase_done_i),
        .phase_o(phase_o), .step_o(step_o), .init_o(init_o),
        .phase_end_o(phase_end_o), .op_end_o(op_end_o),
        .busy_o(busy_o), .lock_o(lock_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string scen = "R1";

    // Behavioural reference state
    int m_run = 0, m_ph = 0, m_st = 0, m_fresh = 0, m_eoo = 0, m_lock = 0, m_cnt = 0;
    logic [NPH-1:0] m_mask = '0;

    task automatic cmp(input string rq, input string nm, input logic [15:0] a,
                       input logic [15:0] e, inout bit bad);
        if (a !== e) begin
            $display("FAIL %s %s (scenario %s) t=%0t actual=%h expected=%h",
                     rq, nm, scen, $time, a, e);
            bad = 1;
        end
    endtask

    // Compare this cycle, advance the reference, wait for next drive point.
    task automatic step();
        bit act, bad, leave, fin, skip;
        logic [15:0] ep, es;
        #1;
        act  = (m_run != 0) && m_mask[m_ph];
        skip = (m_run != 0) && !m_mask[m_ph];
        ep = act ? (16'd1 << m_ph) : 16'd0;
        es = act ? (16'd1 << m_st) : 16'd0;
        bad = 0;
        checks++;
        cmp(skip ? "R3" : "R2", "phase_o", 16'(phase_o), ep, bad);
        cmp("R5", "step_o", 16'(step_o), es, bad);
        cmp("R4", "init_o", 16'(init_o), 16'(act && m_fresh != 0), bad);
        cmp(skip ? "R3" : "R6", "phase_end_o", 16'(phase_end_o), 16'(act && phase_done_i), bad);
        cmp("R7", "op_end_o", 16'(op_end_o), 16'(m_eoo != 0), bad);
        cmp("R7", "busy_o", 16'(busy_o), 16'(m_run != 0), bad);
        cmp("R8", "lock_o", 16'(lock_o), 16'(m_lock != 0), bad);
        if (bad) fails++;
        if (rst) begin
            m_run = 0; m_ph = 0; m_st = 0; m_fresh = 0; m_eoo = 0; m_lock = 0; m_cnt = 0;
            m_mask = '0;
        end else begin
            m_eoo = 0;
            if (m_run == 0) begin
                if (start_i && m_lock == 0) begin
                    m_run = 1; m_ph = 0; m_mask = phase_en_i; m_fresh = 1; m_st = 0; m_cnt = 0;
                end
            end else begin
                leave = !m_mask[m_ph] || phase_done_i;
                fin   = leave && (m_ph == NPH - 1);
                if (m_cnt == TO - 1 && !fin) begin
                    m_lock = 1; m_run = 0; m_st = 0;
                end else if (leave) begin
                    m_st = 0; m_fresh = 1;
                    if (m_ph == NPH - 1) begin m_run = 0; m_eoo = 1; end
                    else m_ph++;
                end else begin
                    m_fresh = 0;
                    if (step_done_i && m_st < NST - 1) m_st++;
                end
                m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst = 1; start_i = 0; step_done_i = 0; phase_done_i = 0;
        for (int i = 0; i < n; i++) step();
        rst = 0;
    endtask

    // One operation with random step/phase-end requests; optional restart noise.
    task automatic run_op(input logic [NPH-1:0] mask, input int pd_pct,
                          input int sd_pct, input bit noise);
        start_i = 1; phase_en_i = mask; step_done_i = 0; phase_done_i = 0;
        step();
        start_i = 0;
        for (int i = 0; i < 200 && m_run != 0; i++) begin
            step_done_i  = ($urandom_range(99) < sd_pct);
            phase_done_i = ($urandom_range(99) < pd_pct);
            if (noise) begin
                start_i    = $urandom_range(1);
                phase_en_i = NPH'($urandom);
            end
            step();
        end
        start_i = 0; step_done_i = 0; phase_done_i = 0;
        step();
        step();
        if (m_lock != 0) do_reset(1);
    endtask

    initial begin
        @(negedge clk);
        scen = "R1";
        do_reset(3);
        step();

        scen = "R2";
        run_op('1, 50, 50, 0);
        run_op('1, 30, 70, 0);

        scen = "R3";
        run_op(8'hA5, 50, 50, 0);
        run_op(8'h80, 60, 40, 0);
        run_op('0, 50, 50, 0);
        run_op(8'h01, 50, 50, 0);

        scen = "R4";
        run_op(8'h5A, 100, 0, 0);

        scen = "R5";
        step_done_i = 1;
        for (int i = 0; i < 4; i++) step();
        step_done_i = 0;
        start_i = 1; phase_en_i = 8'h01;
        step();
        start_i = 0; step_done_i = 1;
        for (int i = 0; i < 14; i++) step();
        phase_done_i = 1;
        step();
        step_done_i = 0; phase_done_i = 0;
        for (int i = 0; i < 10; i++) step();
        step_done_i = 1; phase_done_i = 1;
        start_i = 1; phase_en_i = 8'h0C;
        step();
        start_i = 0;
        for (int i = 0; i < 12; i++) step();
        step_done_i = 0; phase_done_i = 0;

        scen = "R6";
        for (int k = 0; k < 6; k++) run_op(NPH'($urandom), 40, 60, 0);

        scen = "R9";
        for (int k = 0; k < 4; k++) run_op(NPH'($urandom) | 8'h81, 40, 50, 1);

        scen = "R8";
        start_i = 1; phase_en_i = '1;
        step();
        start_i = 0;
        for (int i = 0; i < TO + 6; i++) begin
            step_done_i = $urandom_range(1);
            step();
        end
        start_i = 1; phase_en_i = 8'h01; phase_done_i = 1;
        for (int i = 0; i < 5; i++) step();
        start_i = 0; phase_done_i = 0;
        do_reset(1);
        step();
        run_op(8'h03, 60, 50, 0);

        scen = "R7";
        run_op('1, 70, 50, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete (scenario %s)", scen);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule